// File: doc/BRIEF.md
# Two-Stage Pipelined Wide Magnitude Comparator

This block compares two unsigned operands, 64 bits wide by default, and reports whether the first is larger, the second is larger, or the two are equal. It is meant for a datapath that must start a new comparison every clock. It accepts one operand pair per cycle and returns the verdict for that pair a fixed two cycles later.

The work is split into two stages that have the same logic depth. In the first stage the operands are cut into 8-bit slices. Each slice pair goes to its own small comparator, and that comparator raises a "larger" flag or a "smaller" flag for its slice. The flags are registered. In the second stage a comparator of the same kind treats the larger-flags as one operand and the smaller-flags as the other, and so yields the final verdict.

Each small comparator is built from 4-bit priority lanes. The lane holding the most significant bits always evaluates. Each lower lane is enabled by an AND of the bit-equalities above it. Within a lane, the most significant differing bit decides the result.

Top module: `wide_cmp_pipe`

## Requirements
- R1: While rst_n is low, out_valid, a_gt_b, b_gt_a and a_eq_b are all 0.
- R2: For a pair accepted with in_valid high, a_gt_b is 1 exactly when op_a is greater than op_b as unsigned numbers.
- R3: For a pair accepted with in_valid high, b_gt_a is 1 exactly when op_b is greater than op_a as unsigned numbers.
- R4: For a pair accepted with in_valid high, a_eq_b is 1 exactly when every bit of op_a equals the bit of op_b at the same position.
- R5: Whenever out_valid is 1, exactly one of a_gt_b, b_gt_a and a_eq_b is 1.
- R6: A pair sampled with in_valid high at rising edge k produces out_valid = 1 and its result after rising edge k+2. A cycle with in_valid low produces out_valid = 0 after edge k+2.
- R7: A new pair may be presented on every cycle. Back-to-back pairs each get their own correct result, in the order the pairs were given.
- R8: Operands presented with in_valid low are not captured. While out_valid is 0, the three result outputs keep the last delivered result.
- R9: Group g holds bits 8g to 8g+7, and group 7 is the most significant. The highest-numbered group in which the operands differ alone decides the result, whatever the lower groups hold.
- R10: Within a group, the upper 4-bit lane decides when it differs, and the lower lane's bits are ignored. The lower lane decides only when the upper lane is equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | op_a/op_b carry a pair to compare |
| op_a | input | DATA_W | First unsigned operand |
| op_b | input | DATA_W | Second unsigned operand |
| out_valid | output | 1 | Result outputs carry a new verdict |
| a_gt_b | output | 1 | op_a greater than op_b |
| b_gt_a | output | 1 | op_b greater than op_a |
| a_eq_b | output | 1 | Operands equal |

## Verification
The hardest case to reach from the ports is a slice that is overruled: a lower group or lower lane favours one operand while a more significant position, differing in only one bit, favours the other. Random pairs almost never produce this case, because a random pair differs in its top group with near certainty. The stimulus therefore builds such pairs deliberately for every group boundary and for the nibble boundary inside a group. It also flips single bits at bit 0, at bit 63 and at each group's first bit. The pairs are sent both as isolated transfers and as an unbroken stream, so that the tests expose both misplaced priority and mixing between adjacent pipeline slots.

// File: rtl/wide_cmp_pkg.sv
package wide_cmp_pkg;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } cmp_res_t;

endpackage

// File: rtl/cmp_lane.sv
// Priority lane: the most significant differing bit decides, gated by en.
module cmp_lane #(
    parameter int W = 4
) (
    input  logic         en,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] gt_bits,
    output logic [W-1:0] lt_bits
);
    always_comb begin
        logic tok;
        tok = en;
        for (int i = W - 1; i >= 0; i--) begin
            gt_bits[i] = tok & a[i] & ~b[i];
            lt_bits[i] = tok & ~a[i] & b[i];
            tok        = tok & ~(a[i] ^ b[i]);
        end
    end
endmodule

// File: rtl/cmp_group.sv
// Slice comparator built from priority lanes joined by AND lookahead.
module cmp_group #(
    parameter int W     = 8,
    parameter int SUB_W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         gt,
    output logic         lt
);
    localparam int NSUB = W / SUB_W;

    logic [NSUB-1:0] look;
    logic [W-1:0]    same;
    logic [W-1:0]    gt_all;
    logic [W-1:0]    lt_all;

    assign same = ~(a ^ b);

    always_comb begin
        look[NSUB-1] = 1'b1;
        for (int s = NSUB - 2; s >= 0; s--) begin
            look[s] = look[s+1] & (&same[(s+1)*SUB_W +: SUB_W]);
        end
    end

    for (genvar s = 0; s < NSUB; s++) begin : g_lane
        cmp_lane #(.W(SUB_W)) u_lane (
            .en      (look[s]),
            .a       (a[s*SUB_W +: SUB_W]),
            .b       (b[s*SUB_W +: SUB_W]),
            .gt_bits (gt_all[s*SUB_W +: SUB_W]),
            .lt_bits (lt_all[s*SUB_W +: SUB_W])
        );
    end

    assign gt = |gt_all;
    assign lt = |lt_all;
endmodule

// File: rtl/wide_cmp_pipe.sv
module wide_cmp_pipe
    import wide_cmp_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int GROUP_W = 8,
    parameter int SUB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              out_valid,
    output logic              a_gt_b,
    output logic              b_gt_a,
    output logic              a_eq_b
);
    localparam int NGROUP = DATA_W / GROUP_W;

    typedef struct packed {
        logic              s1_vld;
        logic [NGROUP-1:0] s1_gt;
        logic [NGROUP-1:0] s1_lt;
        logic              out_vld;
        cmp_res_t          res;
    } pipe_t;

    pipe_t             st_d, st_q;
    logic [NGROUP-1:0] grp_gt, grp_lt;
    logic              fin_gt, fin_lt;

    // Stage one: independent slice comparators.
    for (genvar g = 0; g < NGROUP; g++) begin : g_slice
        cmp_group #(.W(GROUP_W), .SUB_W(SUB_W)) u_grp (
            .a  (op_a[g*GROUP_W +: GROUP_W]),
            .b  (op_b[g*GROUP_W +: GROUP_W]),
            .gt (grp_gt[g]),
            .lt (grp_lt[g])
        );
    end

    // Stage two: compare the registered flag vectors.
    cmp_group #(.W(NGROUP), .SUB_W(SUB_W)) u_final (
        .a  (st_q.s1_gt),
        .b  (st_q.s1_lt),
        .gt (fin_gt),
        .lt (fin_lt)
    );

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = in_valid;
        if (in_valid) begin
            st_d.s1_gt = grp_gt;
            st_d.s1_lt = grp_lt;
        end
        st_d.out_vld = st_q.s1_vld;
        if (st_q.s1_vld) begin
            st_d.res.gt = fin_gt;
            st_d.res.lt = fin_lt;
            st_d.res.eq = ~|(st_q.s1_gt | st_q.s1_lt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_vld;
    assign a_gt_b    = st_q.res.gt;
    assign b_gt_a    = st_q.res.lt;
    assign a_eq_b    = st_q.res.eq;
endmodule

// File: rtl/wide_cmp_pipe_chk.sv
module wide_cmp_pipe_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              out_valid,
    input logic              a_gt_b,
    input logic              b_gt_a,
    input logic              a_eq_b
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !a_gt_b && !b_gt_a && !a_eq_b));

    p_gt_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (a_gt_b == ($past(op_a, 2) > $past(op_b, 2))));

    p_lt_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (b_gt_a == ($past(op_b, 2) > $past(op_a, 2))));

    p_eq_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (a_eq_b == ($past(op_a, 2) == $past(op_b, 2))));

    p_one_hot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({a_gt_b, b_gt_a, a_eq_b}) == 1));

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    p_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable({a_gt_b, b_gt_a, a_eq_b}));
endmodule

bind wide_cmp_pipe wide_cmp_pipe_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/wide_cmp_pipe_bench.sv
module wide_cmp_pipe_bench;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] op_a = '0;
    logic [DW-1:0] op_b = '0;
    logic          out_valid, a_gt_b, b_gt_a, a_eq_b;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    wide_cmp_pipe #(.DATA_W(DW)) u_wide_cmp_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .a_gt_b(a_gt_b), .b_gt_a(b_gt_a), .a_eq_b(a_eq_b)
    );

    task automatic check_bits(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual {vld,gt,lt,eq}=%b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] expect_of(input logic [DW-1:0] a, input logic [DW-1:0] b);
        return {1'b1, a > b, b > a, a == b};
    endfunction

    // Isolated transfer: drive, drop valid, check after the second edge.
    task automatic send_one(input string req, input logic [DW-1:0] a, input logic [DW-1:0] b);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check_bits(req, {out_valid, a_gt_b, b_gt_a, a_eq_b}, expect_of(a, b));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check_bits("R1 reset", {out_valid, a_gt_b, b_gt_a, a_eq_b}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_equal;
        send_one("R4 equal zero", '0, '0);
        send_one("R4 equal ones", '1, '1);
        send_one("R4 equal pattern", 64'hA5C3_0F1E_7788_9911, 64'hA5C3_0F1E_7788_9911);
    endtask

    task automatic t_edges;
        send_one("R2 bit0 a larger", 64'h1234_5678_9ABC_DEF1, 64'h1234_5678_9ABC_DEF0);
        send_one("R3 bit0 b larger", 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001);
        send_one("R2 bit63 a larger", 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000);
        send_one("R3 bit63 b larger", 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_boundaries;
        for (int g = 0; g < 8; g++) begin
            logic [DW-1:0] base;
            base = {$urandom, $urandom};
            send_one("R9 group low bit", base, base ^ (64'd1 << (8 * g)));
            send_one("R9 group high bit", base, base ^ (64'd1 << (8 * g + 7)));
        end
    endtask

    // Higher group decides by one bit while every lower group favours the other side.
    task automatic t_group_priority;
        for (int g = 1; g < 8; g++) begin
            logic [DW-1:0] a, b, low_mask;
            low_mask = (64'd1 << (8 * g)) - 64'd1;
            a = (64'd1 << (8 * g)) & ~low_mask;
            b = low_mask;
            send_one("R9 higher group overrules", a, b);
            send_one("R9 higher group overrules swapped", b, a);
        end
    endtask

    // Upper nibble decides by one bit while the lower nibble points the other way.
    task automatic t_nibble;
        send_one("R10 upper lane wins", 64'h0000_0000_0000_0010, 64'h0000_0000_0000_000F);
        send_one("R10 upper lane wins b", 64'h0000_0000_0F00_0000, 64'h0000_0000_1000_0000);
        send_one("R10 lower lane decides", 64'h0000_0000_0000_3A00, 64'h0000_0000_0000_3B00);
        send_one("R10 lower lane decides a", 64'h0000_0000_0000_0097, 64'h0000_0000_0000_0096);
    endtask

    task automatic t_stream;
        logic [DW-1:0] sa [8];
        logic [DW-1:0] sb [8];
        for (int i = 0; i < 8; i++) begin
            sa[i] = {$urandom, $urandom};
            sb[i] = (i % 3 == 0) ? sa[i] : (sa[i] ^ (64'd1 << (i * 9)));
        end
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i >= 2)
                check_bits("R7 stream in order", {out_valid, a_gt_b, b_gt_a, a_eq_b},
                           expect_of(sa[i-2], sb[i-2]));
            if (i < 8) begin
                in_valid = 1'b1; op_a = sa[i]; op_b = sb[i];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic t_hold;
        logic [3:0] last;
        send_one("R6 latency", 64'd5, 64'd9);
        last = {1'b0, 1'b0, 1'b1, 1'b0};
        op_a = '1; op_b = '0;
        repeat (3) @(negedge clk);
        check_bits("R8 ignored while idle", {out_valid, a_gt_b, b_gt_a, a_eq_b}, last);
        @(negedge clk);
        in_valid = 1'b1; op_a = 64'd7; op_b = 64'd7;
        @(negedge clk);
        in_valid = 1'b0;
        check_bits("R6 not yet valid", {out_valid, a_gt_b, b_gt_a, a_eq_b}, last);
        @(negedge clk);
        check_bits("R6 valid after two edges", {out_valid, a_gt_b, b_gt_a, a_eq_b}, 4'b1001);
    endtask

    task automatic t_random;
        for (int i = 0; i < 40; i++) begin
            logic [DW-1:0] a, b;
            a = {$urandom, $urandom};
            b = (i % 4 == 0) ? (a ^ (64'd1 << ($urandom % 64))) : {$urandom, $urandom};
            send_one("R2 R3 R5 random", a, b);
        end
    endtask

    initial begin
        t_reset();
        t_equal();
        t_edges();
        t_boundaries();
        t_group_priority();
        t_nibble();
        t_stream();
        t_hold();
        t_random();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog: actual no completion expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule